// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a general-purpose pin controller for a system-on-chip peripheral bus. Software programs it through eight word registers on a simple single-transfer slave port. Each pin can be an output, driven either from a software data register or from a matching auxiliary input, or it can be an input. Input pins are synchronised and sampled, and each one can raise an interrupt on a rising or a falling edge, chosen per bit.

Register state advances on an update strobe. By default the strobe fires on every system clock. Software can instead take the strobe from an external clock pin, on its rising or its falling edge. Interrupt events collect in a sticky per-bit flag register and a summary flag in the control register. The summary flag drives the single level interrupt output.

Register map by byte offset: 0x00 sampled inputs (read only), 0x04 output data, 0x08 output enable, 0x0C per-bit interrupt enable, 0x10 per-bit edge polarity, 0x14 auxiliary select, 0x18 control, 0x1C interrupt flags. Control bits: bit 0 interrupt enable, bit 1 interrupt summary flag, bit 2 external strobe select, bit 3 falling-edge select.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq`, `pin_out` and `pin_oe` are 0.
- R2: A read of offset 0x00 returns the sampled inputs ORed with the output data register. A write to 0x00 changes nothing.
- R3: Every transfer is acknowledged by a one-cycle `bus_ack` pulse, two clock edges after `bus_stb` is first seen. Registers at 0x04 to 0x1C read back what was written. Control keeps only bits 3:0.
- R4: On each update, `pin_oe` takes the output-enable register. Each `pin_out` bit takes `aux_in` where the auxiliary-select bit is 1 and the output data bit where it is 0, and is then ANDed with output enable.
- R5: On each update, the sampled input takes the synchronised pins ANDed with the inverse of output enable.
- R6: On an update with control bit 0 set, a sampled bit that rose with polarity bit 1, or fell with polarity bit 0, is relevant. Relevant bits that are also set in the interrupt-enable register are ORed into the flag register, and control bit 1 is set. With control bit 0 clear, or the enable bit clear, no flag is set.
- R7: Flag bits stay set until software writes offset 0x1C. `irq` equals control bit 1 and clears only when control is written.
- R8: With control bit 2 set, updates happen only on an external clock edge: rising when bit 3 is 0 and falling when bit 3 is 1. No system-clock updates occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_stb | input | 1 | Transfer request, held until acknowledged |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_adr | input | 5 | Byte offset of the register |
| bus_wdat | input | DATA_W | Write data |
| bus_rdat | output | DATA_W | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle transfer acknowledge |
| pin_in | input | NPIN | Asynchronous pin inputs |
| aux_in | input | NPIN | Alternative output sources |
| ext_clk | input | 1 | Asynchronous external update clock |
| pin_out | output | NPIN | Pin output data |
| pin_oe | output | NPIN | Pin output enables |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded assertions check on every cycle that the acknowledge is a single pulse preceded by two cycles of request. They also check that output data never shows on a disabled pin, that flag bits only clear through a flag write, that a rise of the interrupt line needs the enable bit or a control write, and that nothing updates between external edges when the external strobe is selected. Only the bench's scenarios can show the values themselves: the output multiplexing under a sweep of data, select and enable patterns, the per-bit edge polarity, the composed input readback, and which external edge steps the block.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // Word index decoded from byte offset bits [4:2]
   typedef enum logic [2:0] {
      REG_IN   = 3'd0,
      REG_OUT  = 3'd1,
      REG_OE   = 3'd2,
      REG_IEN  = 3'd3,
      REG_TRIG = 3'd4,
      REG_ALT  = 3'd5,
      REG_CTRL = 3'd6,
      REG_FLAG = 3'd7
   } reg_sel_e;

   localparam int CTRL_W  = 4;
   localparam int CB_IEN  = 0;   // interrupt detection enable
   localparam int CB_FLAG = 1;   // summary interrupt flag
   localparam int CB_XCLK = 2;   // external update strobe
   localparam int CB_XNEG = 3;   // falling external edge
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[0] <= '0;
               else        st[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= '0;
               else        st[i] <= st[i-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_bus_if.sv
module gpio_bus_if
   import gpio_edge_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              we,
   input  logic [4:0]        adr,
   input  logic [DATA_W-1:0] rd_val,
   output reg_sel_e          sel,
   output logic              wr_en,
   output logic              ack,
   output logic [DATA_W-1:0] rdat
);
   logic pend;
   logic aligned;

   assign sel     = reg_sel_e'(adr[4:2]);
   assign aligned = (adr[1:0] == 2'b00);
   assign wr_en   = pend && we && aligned;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         ack  <= 1'b0;
         rdat <= '0;
      end else begin
         pend <= stb && !pend && !ack;
         ack  <= pend;
         if (pend) rdat <= (aligned && !we) ? rd_val : '0;
      end
   end

   a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   a_r3_ack_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> ($past(stb) && $past(stb, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_edge_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdat,
   input  logic [NPIN-1:0]   pin_s,
   input  logic [NPIN-1:0]   aux_in,
   input  logic              tick,
   output logic [DATA_W-1:0] rd_val,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   output logic              xclk_sel,
   output logic              xneg_sel,
   output logic              irq
);
   logic [NPIN-1:0]   out_r, oe_r, ien_r, trig_r, alt_r, flag_r, in_r;
   logic [CTRL_W-1:0] ctrl_r, ctrl_nx;
   logic [NPIN-1:0]   flag_nx, in_new, rose, fell, rel, hit;
   logic [NPIN-1:0]   wd;

   assign wd     = wdat[NPIN-1:0];
   assign in_new = pin_s & ~oe_r;
   assign rose   = in_new & ~in_r;
   assign fell   = in_r & ~in_new;
   assign rel    = (trig_r & rose) | (~trig_r & fell);
   assign hit    = (tick && ctrl_r[CB_IEN]) ? (rel & ien_r) : '0;

   always_comb begin
      ctrl_nx = (wr_en && sel == REG_CTRL) ? wdat[CTRL_W-1:0] : ctrl_r;
      flag_nx = (wr_en && sel == REG_FLAG) ? wd : flag_r;
      flag_nx = flag_nx | hit;
      if (|hit) ctrl_nx[CB_FLAG] = 1'b1;
   end

   always_comb begin
      case (sel)
         REG_IN:   rd_val = DATA_W'(in_r | out_r);
         REG_OUT:  rd_val = DATA_W'(out_r);
         REG_OE:   rd_val = DATA_W'(oe_r);
         REG_IEN:  rd_val = DATA_W'(ien_r);
         REG_TRIG: rd_val = DATA_W'(trig_r);
         REG_ALT:  rd_val = DATA_W'(alt_r);
         REG_CTRL: rd_val = DATA_W'(ctrl_r);
         default:  rd_val = DATA_W'(flag_r);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_r   <= '0;
         oe_r    <= '0;
         ien_r   <= '0;
         trig_r  <= '0;
         alt_r   <= '0;
         flag_r  <= '0;
         in_r    <= '0;
         ctrl_r  <= '0;
         pin_out <= '0;
         pin_oe  <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               REG_OUT:  out_r  <= wd;
               REG_OE:   oe_r   <= wd;
               REG_IEN:  ien_r  <= wd;
               REG_TRIG: trig_r <= wd;
               REG_ALT:  alt_r  <= wd;
               default:  ;
            endcase
         end
         ctrl_r <= ctrl_nx;
         flag_r <= flag_nx;
         if (tick) begin
            in_r    <= in_new;
            pin_out <= ((out_r & ~alt_r) | (aux_in & alt_r)) & oe_r;
            pin_oe  <= oe_r;
         end
      end
   end

   assign irq      = ctrl_r[CB_FLAG];
   assign xclk_sel = ctrl_r[CB_XCLK];
   assign xneg_sel = ctrl_r[CB_XNEG];

   a_r4_oe_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == REG_FLAG) |=> ((flag_r & $past(flag_r)) == $past(flag_r)));
   a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(ctrl_r[CB_IEN]) || $past(wr_en && sel == REG_CTRL)));
   a_r8_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_r[CB_XCLK] && !tick) |=> ($stable(in_r) && $stable(pin_out) && $stable(pin_oe)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int NPIN        = 32,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_stb,
   input  logic              bus_we,
   input  logic [4:0]        bus_adr,
   input  logic [DATA_W-1:0] bus_wdat,
   output logic [DATA_W-1:0] bus_rdat,
   output logic              bus_ack,
   input  logic [NPIN-1:0]   pin_in,
   input  logic [NPIN-1:0]   aux_in,
   input  logic              ext_clk,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   output logic              irq
);
   localparam int SW = NPIN + 1;

   initial begin
      if (NPIN < 1 || NPIN > DATA_W) $fatal(1, "NPIN must be in 1..DATA_W");
      if (DATA_W < CTRL_W)           $fatal(1, "DATA_W too narrow for control");
      if (SYNC_STAGES < 2)           $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [SW-1:0]     sync_q;
   logic [NPIN-1:0]   pin_s;
   logic              xs, xs_prev, xclk_sel, xneg_sel, tick, wr_en;
   logic [DATA_W-1:0] rd_val;
   reg_sel_e          sel;

   gpio_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d({ext_clk, pin_in}), .q(sync_q));

   assign pin_s = sync_q[NPIN-1:0];
   assign xs    = sync_q[NPIN];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) xs_prev <= 1'b0;
      else        xs_prev <= xs;

   assign tick = !xclk_sel ? 1'b1
               : (xneg_sel ? (xs_prev && !xs) : (xs && !xs_prev));

   gpio_bus_if #(.DATA_W(DATA_W)) i_bus (
      .clk(clk), .rst_n(rst_n), .stb(bus_stb), .we(bus_we), .adr(bus_adr),
      .rd_val(rd_val), .sel(sel), .wr_en(wr_en), .ack(bus_ack), .rdat(bus_rdat));

   gpio_regs #(.NPIN(NPIN), .DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdat(bus_wdat),
      .pin_s(pin_s), .aux_in(aux_in), .tick(tick), .rd_val(rd_val),
      .pin_out(pin_out), .pin_oe(pin_oe), .xclk_sel(xclk_sel),
      .xneg_sel(xneg_sel), .irq(irq));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_stb = 1'b0, bus_we = 1'b0;
   logic [4:0]  bus_adr = '0;
   logic [31:0] bus_wdat = '0, bus_rdat;
   logic        bus_ack;
   logic [31:0] pin_in = '0, aux_in = '0, pin_out, pin_oe;
   logic        ext_clk = 1'b0, irq;

   int n_run = 0, n_fail = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   gpio_edge_ctrl i_gpio_edge_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
      .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
      .bus_ack(bus_ack), .pin_in(pin_in), .aux_in(aux_in), .ext_clk(ext_clk),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic w, input logic [4:0] a, input logic [31:0] d,
                       output logic [31:0] r, output int lat);
      @(negedge clk);
      bus_stb = 1'b1; bus_we = w; bus_adr = a; bus_wdat = d;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!bus_ack && lat < 20);
      r = bus_rdat;
      bus_stb = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      logic [31:0] r; int lat;
      xfer(1'b1, a, d, r, lat);
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] r);
      int lat;
      xfer(1'b0, a, 32'h0, r, lat);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r, e;
      int lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle(2);

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(5'(a * 4), r);
         check("R1 reg reset", r, 32'h0);
      end
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 pin_out", pin_out, 32'h0);
      check("R1 pin_oe", pin_oe, 32'h0);

      // R3: acknowledge latency and readback
      xfer(1'b1, 5'h04, 32'hA5A5_0F0F, r, lat);
      check("R3 ack latency", 32'(lat), 32'd2);
      @(posedge clk); #1;
      check("R3 ack single pulse", {31'h0, bus_ack}, 32'h0);
      rd(5'h04, r); check("R3 out readback", r, 32'hA5A5_0F0F);
      wr(5'h0C, 32'h1234_5678); rd(5'h0C, r); check("R3 ien readback", r, 32'h1234_5678);
      wr(5'h10, 32'h8765_4321); rd(5'h10, r); check("R3 trig readback", r, 32'h8765_4321);
      wr(5'h14, 32'h0000_FFFF); rd(5'h14, r); check("R3 alt readback", r, 32'h0000_FFFF);
      wr(5'h18, 32'hFFFF_FFF4); rd(5'h18, r); check("R3 ctrl keeps 3:0", r, 32'h0000_0004);
      wr(5'h18, 32'h0);
      wr(5'h1C, 32'h0000_00C3); rd(5'h1C, r); check("R3 flag readback", r, 32'h0000_00C3);
      wr(5'h1C, 32'h0);
      wr(5'h0C, 32'h0); wr(5'h10, 32'h0); wr(5'h14, 32'h0); wr(5'h04, 32'h0);

      // R2 / R5: input readback with output data and OE masking
      pin_in = 32'hFFFF_FFFF;
      wr(5'h08, 32'h0000_FF00);
      wr(5'h04, 32'h0000_1200);
      settle(5);
      rd(5'h00, r);
      check("R2 R5 in readback", r, (32'hFFFF_FFFF & ~32'h0000_FF00) | 32'h0000_1200);
      wr(5'h00, 32'h0);
      rd(5'h00, r);
      check("R2 write to in ignored", r, 32'hFFFF_00FF | 32'h0000_1200);
      pin_in = 32'h3C00_0081;
      wr(5'h08, 32'h0); wr(5'h04, 32'h0);
      settle(5);
      rd(5'h00, r);
      check("R5 all inputs", r, 32'h3C00_0081);

      // R4: sweep of output data and select nibbles
      aux_in = 32'h3C3C_A5A5;
      wr(5'h08, 32'h0F0F_F0FF);
      for (int o = 0; o < 16; o++) begin
         for (int s = 0; s < 16; s++) begin
            logic [31:0] ov, sv;
            ov = {8{4'(o)}}; sv = {8{4'(s)}};
            wr(5'h04, ov); wr(5'h14, sv);
            settle(2);
            e = ((ov & ~sv) | (aux_in & sv)) & 32'h0F0F_F0FF;
            check("R4 pin_out mux", pin_out, e);
         end
      end
      check("R4 pin_oe", pin_oe, 32'h0F0F_F0FF);
      wr(5'h08, 32'h0); wr(5'h04, 32'h0); wr(5'h14, 32'h0);

      // R6: per-bit edge polarity
      pin_in = 32'h0; settle(5);
      wr(5'h0C, 32'hFFFF_FFFF);
      for (int b = 0; b < 8; b++) begin
         for (int t = 0; t < 2; t++) begin
            wr(5'h10, t ? 32'hFFFF_FFFF : 32'h0);
            wr(5'h1C, 32'h0); wr(5'h18, 32'h1);
            pin_in[b] = 1'b1; settle(5);
            rd(5'h1C, r);
            check("R6 rising edge", r, t ? (32'h1 << b) : 32'h0);
            check("R6 irq on rise", {31'h0, irq}, 32'(t));
            wr(5'h1C, 32'h0); wr(5'h18, 32'h1);
            pin_in[b] = 1'b0; settle(5);
            rd(5'h1C, r);
            check("R6 falling edge", r, t ? 32'h0 : (32'h1 << b));
            check("R6 irq on fall", {31'h0, irq}, 32'(1 - t));
         end
      end
      // R6: enable bit masking and global enable
      wr(5'h10, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFD);
      wr(5'h1C, 32'h0); wr(5'h18, 32'h1);
      pin_in = 32'h2; settle(5);
      rd(5'h1C, r); check("R6 ien mask", r, 32'h0);
      pin_in = 32'h0; settle(5);
      wr(5'h0C, 32'hFFFF_FFFF); wr(5'h18, 32'h0);
      pin_in = 32'h10; settle(5);
      rd(5'h1C, r); check("R6 global enable off", r, 32'h0);
      check("R6 irq stays low", {31'h0, irq}, 32'h0);

      // R7: sticky flags and irq clearing
      pin_in = 32'h0; settle(5);
      wr(5'h18, 32'h1);
      pin_in = 32'h20; settle(5);
      pin_in = 32'h0;  settle(5);
      pin_in = 32'h100; settle(5);
      rd(5'h1C, r); check("R7 flags accumulate", r, 32'h0000_0120);
      wr(5'h1C, 32'h0);
      rd(5'h1C, r); check("R7 flag write clears", r, 32'h0);
      check("R7 irq held after flag write", {31'h0, irq}, 32'h1);
      wr(5'h18, 32'h1);
      check("R7 irq cleared by ctrl", {31'h0, irq}, 32'h0);
      wr(5'h18, 32'h0); pin_in = 32'h0; settle(5);

      // R8: external strobe, rising edge
      ext_clk = 1'b0; settle(5);
      wr(5'h18, 32'h4);
      pin_in = 32'h0000_00F0; settle(8);
      rd(5'h00, r); check("R8 no update without edge", r, 32'h0);
      ext_clk = 1'b1; settle(6);
      rd(5'h00, r); check("R8 rising edge updates", r, 32'h0000_00F0);
      pin_in = 32'h0000_000F; ext_clk = 1'b0; settle(6);
      rd(5'h00, r); check("R8 falling edge ignored", r, 32'h0000_00F0);
      // R8: falling edge selected
      wr(5'h18, 32'hC);
      ext_clk = 1'b1; settle(6);
      rd(5'h00, r); check("R8 rising ignored with neg", r, 32'h0000_00F0);
      ext_clk = 1'b0; settle(6);
      rd(5'h00, r); check("R8 falling edge updates", r, 32'h0000_000F);
      wr(5'h08, 32'hFF); wr(5'h04, 32'h55); settle(6);
      check("R8 outputs wait for edge", pin_out, 32'h0);
      ext_clk = 1'b1; settle(6); ext_clk = 1'b0; settle(6);
      check("R8 outputs after edge", pin_out, 32'h55);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule